// File: doc/BRIEF.md
# Debug Communications Mailbox Channel

This block is a two-way, one-word mailbox between an external debug host and an on-chip processor, both in a single clock domain. The host reaches it through a small register port with 5-bit addresses. A control/status word reports two handshake flags and a fixed version code. A data address carries words in both directions: a host write goes toward the core, and a host read collects from the core. The core has its own strobed read and write port on the same two data registers.

Each direction keeps one word register and one pending flag. The host-to-core flag (`tx_pend`, reported as the R flag) is set while a word written by the host has not yet been read by the core. The core-to-host flag (`rx_pend`, reported as the W flag) is set while a word written by the core waits for the host. A host read of the data address consumes the waiting word. For that reason, software polls the control address and reads the data address only once per word.

Top module: `dbgmb_channel`

## Requirements
- R1: After a synchronous reset, both flags are 0 and `host_rdata` and `core_rdata` are 0.
- R2: A host read of the control address (`CTRL_ADDR`, default 0x04) returns the host-to-core flag in bit 0, the core-to-host flag in bit 1 and `VERSION` (default 4'h3) in bits [31:28]. Bits [27:2] read as 0.
- R3: A host write to the data address (`DATA_ADDR`, default 0x05) stores the word and sets bit 0. A later core read returns that word on `core_rdata` one cycle after the strobe and clears bit 0.
- R4: A core write stores the word and sets bit 1. A later host read of the data address returns that word on `host_rdata` one cycle after the strobe and clears bit 1.
- R5: A host read of the control address changes neither flag.
- R6: A host write while bit 0 is set replaces the pending word and leaves bit 0 set. A core write while bit 1 is set replaces the waiting word and leaves bit 1 set.
- R7: Host writes to the control address or to any unmapped address are ignored. Host reads of unmapped addresses return 0.
- R8: When a host data write and a core read fall in the same cycle, the core receives the previous word, and bit 0 ends set with the new word pending.
- R9: When a core write and a host data read fall in the same cycle, the host receives the previous word, and bit 1 ends set with the new word waiting.
- R10: A host read of the data address while bit 1 is 0 returns the last word held and leaves bit 1 at 0. A core read while bit 0 is 0 leaves bit 0 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Host register address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Registered host read data |
| core_wr | input | 1 | Core write strobe (core-to-host word) |
| core_wdata | input | DATA_W | Core write data |
| core_rd | input | 1 | Core read strobe (host-to-core word) |
| core_rdata | output | DATA_W | Registered core read data |

## Verification
The cases that need care are a put and a take on the same register in the same cycle. One is a host data write together with a core read. The other is a core write together with a host data read. The bench drives both strobes in one cycle and checks two things: that the taking side receives the older word, and that a following control read shows the flag still set and the new word deliverable. It also checks the flag-clearing path on its own, so that a design that gives the take priority is told apart from one that gives the put priority.

// File: rtl/dbgmb_pkg.sv
package dbgmb_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_DATA = 2'd2
  } host_sel_e;

  localparam int TX_FLAG_BIT = 0;
  localparam int RX_FLAG_BIT = 1;
  localparam int VER_W       = 4;
endpackage

// File: rtl/dbgmb_slot.sv
// One direction of the mailbox: a word register plus a pending flag.
module dbgmb_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         put,
  input  logic [W-1:0] put_data,
  input  logic         take,
  output logic [W-1:0] word,
  output logic         pending
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word    <= '0;
      pending <= 1'b0;
    end else begin
      if (put) word <= put_data;
      // a put in the same cycle as a take wins: the new word stays pending
      if (put)       pending <= 1'b1;
      else if (take) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/dbgmb_host_if.sv
// Host address decode and registered read mux.
module dbgmb_host_if
  import dbgmb_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 5,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'h04,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 5'h05,
  parameter logic [VER_W-1:0]  VERSION   = 4'h3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              tx_pend,
  input  logic              rx_pend,
  input  logic [DATA_W-1:0] rx_word,
  output logic              data_put,
  output logic              data_take,
  output logic [DATA_W-1:0] host_rdata
);
  localparam int RSV_W = DATA_W - VER_W - 2;

  host_sel_e         sel;
  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    if (host_addr == CTRL_ADDR)      sel = SEL_CTRL;
    else if (host_addr == DATA_ADDR) sel = SEL_DATA;
    else                             sel = SEL_NONE;
  end

  assign ctrl_word = {VERSION, {RSV_W{1'b0}}, rx_pend, tx_pend};
  assign data_put  = host_wr && (sel == SEL_DATA);
  assign data_take = host_rd && (sel == SEL_DATA);

  always_comb begin
    unique case (sel)
      SEL_CTRL: rd_mux = ctrl_word;
      SEL_DATA: rd_mux = rx_word;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_mux;
  end
endmodule

// File: rtl/dbgmb_channel.sv
module dbgmb_channel
  import dbgmb_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                ADDR_W    = 5,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'h04,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 5'h05,
  parameter logic [VER_W-1:0]  VERSION   = 4'h3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              core_wr,
  input  logic [DATA_W-1:0] core_wdata,
  input  logic              core_rd,
  output logic [DATA_W-1:0] core_rdata
);
  logic              data_put, data_take;
  logic              tx_pend, rx_pend;
  logic [DATA_W-1:0] tx_word, rx_word;

  dbgmb_host_if #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
    .DATA_ADDR(DATA_ADDR), .VERSION(VERSION)
  ) u_host (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .tx_pend(tx_pend), .rx_pend(rx_pend),
    .rx_word(rx_word), .data_put(data_put), .data_take(data_take),
    .host_rdata(host_rdata)
  );

  // host -> core
  dbgmb_slot #(.W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .put(data_put), .put_data(host_wdata),
    .take(core_rd), .word(tx_word), .pending(tx_pend)
  );

  // core -> host
  dbgmb_slot #(.W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .put(core_wr), .put_data(core_wdata),
    .take(data_take), .word(rx_word), .pending(rx_pend)
  );

  always_ff @(posedge clk) begin
    if (rst)          core_rdata <= '0;
    else if (core_rd) core_rdata <= tx_word;
  end
endmodule

// File: rtl/dbgmb_channel_chk.sv
module dbgmb_channel_chk
  import dbgmb_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                ADDR_W    = 5,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'h04,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 5'h05,
  parameter logic [VER_W-1:0]  VERSION   = 4'h3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_wr,
  input logic              host_rd,
  input logic [DATA_W-1:0] host_rdata,
  input logic              core_wr,
  input logic              core_rd,
  input logic              tx_pend,
  input logic              rx_pend
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!tx_pend && !rx_pend));

  a_r2_ctrl_layout: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == CTRL_ADDR) |=>
      (host_rdata[DATA_W-1 -: VER_W] == VERSION &&
       host_rdata[DATA_W-VER_W-1:2] == '0));

  a_r3_host_put_sets: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == DATA_ADDR) |=> tx_pend);

  a_r3_core_take_clears: assert property (@(posedge clk) disable iff (rst)
    (core_rd && !(host_wr && host_addr == DATA_ADDR)) |=> !tx_pend);

  a_r4_core_put_sets: assert property (@(posedge clk) disable iff (rst)
    core_wr |=> rx_pend);

  a_r4_host_take_clears: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == DATA_ADDR && !core_wr) |=> !rx_pend);

  a_r5_ctrl_read_quiet: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == CTRL_ADDR && !host_wr && !core_wr && !core_rd)
      |=> ($stable(tx_pend) && $stable(rx_pend)));
endmodule

bind dbgmb_channel dbgmb_channel_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
  .DATA_ADDR(DATA_ADDR), .VERSION(VERSION)
) u_chk (
  .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
  .host_rd(host_rd), .host_rdata(host_rdata), .core_wr(core_wr),
  .core_rd(core_rd), .tx_pend(tx_pend), .rx_pend(rx_pend)
);

// File: tb/test_dbgmb_channel.sv
module test_dbgmb_channel;
  localparam int DW = 32;
  localparam logic [4:0] A_CTRL = 5'h04;
  localparam logic [4:0] A_DATA = 5'h05;
  localparam logic [31:0] VER_BITS = 32'h3000_0000;

  logic clk = 0, rst = 1;
  logic [4:0]    host_addr = '0;
  logic          host_wr = 0, host_rd = 0, core_wr = 0, core_rd = 0;
  logic [DW-1:0] host_wdata = '0, core_wdata = '0;
  logic [DW-1:0] host_rdata, core_rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dbgmb_channel i_dbgmb_channel (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .core_wr(core_wr), .core_wdata(core_wdata), .core_rd(core_rd),
    .core_rdata(core_rdata)
  );

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive strobes for one cycle; results are sampled at the following negedge
  task automatic cyc(logic hw, logic hr, logic [4:0] a, logic [DW-1:0] hd,
                     logic cw, logic cr, logic [DW-1:0] cd);
    @(negedge clk);
    host_wr = hw; host_rd = hr; host_addr = a; host_wdata = hd;
    core_wr = cw; core_rd = cr; core_wdata = cd;
    @(negedge clk);
    host_wr = 0; host_rd = 0; core_wr = 0; core_rd = 0;
  endtask

  task automatic h_wr(logic [4:0] a, logic [DW-1:0] d); cyc(1,0,a,d,0,0,'0); endtask
  task automatic h_rd(logic [4:0] a, output logic [DW-1:0] d);
    cyc(0,1,a,'0,0,0,'0); d = host_rdata;
  endtask
  task automatic c_wr(logic [DW-1:0] d); cyc(0,0,A_CTRL,'0,1,0,d); endtask
  task automatic c_rd(output logic [DW-1:0] d); cyc(0,0,A_CTRL,'0,0,1,'0); d = core_rdata; endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    chk("R1 host_rdata", host_rdata, '0);
    chk("R1 core_rdata", core_rdata, '0);
    h_rd(A_CTRL, v);
    chk("R1/R2 ctrl after reset", v, VER_BITS);
  endtask

  task automatic t_host_to_core;
    logic [DW-1:0] v;
    h_wr(A_DATA, 32'hCAFE_0001);
    h_rd(A_CTRL, v); chk("R3 R set", v, VER_BITS | 32'h1);
    h_rd(A_CTRL, v); chk("R5 ctrl reread unchanged", v, VER_BITS | 32'h1);
    c_rd(v);         chk("R3 core data", v, 32'hCAFE_0001);
    h_rd(A_CTRL, v); chk("R3 R cleared", v, VER_BITS);
    c_rd(v);         chk("R10 core read idle", v, 32'hCAFE_0001);
    h_rd(A_CTRL, v); chk("R10 R stays 0", v, VER_BITS);
  endtask

  task automatic t_core_to_host;
    logic [DW-1:0] v;
    c_wr(32'h1234_5678);
    h_rd(A_CTRL, v); chk("R4 W set", v, VER_BITS | 32'h2);
    h_rd(A_DATA, v); chk("R4 host data", v, 32'h1234_5678);
    h_rd(A_CTRL, v); chk("R4 W cleared", v, VER_BITS);
    h_rd(A_DATA, v); chk("R10 stale data", v, 32'h1234_5678);
    h_rd(A_CTRL, v); chk("R10 W stays 0", v, VER_BITS);
  endtask

  task automatic t_overwrite;
    logic [DW-1:0] v;
    h_wr(A_DATA, 32'hAAAA_0001);
    h_wr(A_DATA, 32'hAAAA_0002);
    c_wr(32'hBBBB_0001);
    c_wr(32'hBBBB_0002);
    h_rd(A_CTRL, v); chk("R6 both flags", v, VER_BITS | 32'h3);
    c_rd(v);         chk("R6 host word replaced", v, 32'hAAAA_0002);
    h_rd(A_DATA, v); chk("R6 core word replaced", v, 32'hBBBB_0002);
    h_rd(A_CTRL, v); chk("R6 both clear", v, VER_BITS);
  endtask

  task automatic t_ignored;
    logic [DW-1:0] v;
    h_wr(A_CTRL, 32'hFFFF_FFFF);
    h_rd(A_CTRL, v); chk("R7 ctrl write ignored", v, VER_BITS);
    h_wr(5'h1F, 32'h5555_5555);
    h_rd(A_CTRL, v); chk("R7 unmapped write no flag", v, VER_BITS);
    c_rd(v);         chk("R7 unmapped write no data", v, 32'hAAAA_0002);
    h_rd(5'h00, v);  chk("R7 unmapped read zero", v, '0);
  endtask

  task automatic t_collide;
    logic [DW-1:0] v;
    h_wr(A_DATA, 32'h0000_00A1);
    cyc(1,0,A_DATA,32'h0000_00A2,0,1,'0);
    chk("R8 core gets old word", core_rdata, 32'h0000_00A1);
    h_rd(A_CTRL, v); chk("R8 R stays set", v, VER_BITS | 32'h1);
    c_rd(v);         chk("R8 new word delivered", v, 32'h0000_00A2);
    c_wr(32'h0000_00B1);
    cyc(0,1,A_DATA,'0,1,0,32'h0000_00B2);
    chk("R9 host gets old word", host_rdata, 32'h0000_00B1);
    h_rd(A_CTRL, v); chk("R9 W stays set", v, VER_BITS | 32'h2);
    h_rd(A_DATA, v); chk("R9 new word delivered", v, 32'h0000_00B2);
    h_rd(A_CTRL, v); chk("R9 W cleared", v, VER_BITS);
  endtask

  task automatic t_reset_mid;
    logic [DW-1:0] v;
    h_wr(A_DATA, 32'h7);
    c_wr(32'h8);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    h_rd(A_CTRL, v); chk("R1 flags clear after reset", v, VER_BITS);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_host_to_core();
    t_core_to_host();
    t_overwrite();
    t_ignored();
    t_collide();
    t_reset_mid();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule